// File: doc/BRIEF.md
# Step Attenuator Control Interface

This block is the digital control front end of a 6-bit step attenuator. It produces a registered attenuation code whose bits weigh 0.5, 1, 2, 4, 8 and 16 units, so 64 settings are available. A mode input chooses how the code is written. In parallel mode, six control pins supply the word. In serial mode, a data/clock pair shifts the word into a 6-bit register. In both modes a latch-enable input acts as a level-sensitive gate: while it is high the output tracks its source, and while it is low the output holds.

Every external control is sampled on a fast system clock through a two-flop synchronizer. Serial clock edges are detected on the synchronized copy of the serial clock. A short warm-up follows reset release, and once the synchronizers have filled the block loads a power-up code. In serial mode the power-up code comes from the parallel pins. In parallel mode with the gate low, it is one of four presets picked by two select bits. The output keeps that code until the gate is first seen high.

Top module: `step_atten_ctrl`

## Requirements
- R1: In parallel mode (ser_mode_i=0) with latch_en_i low during and after reset, the output settles within SYNC_STAGES+1 clocks of reset release to a preset chosen by pup_sel_i ({PUP2,PUP1}): 00 gives 0, 01 gives 8, 10 gives 16 and 11 gives 63.
- R2: If ser_mode_i=1 at power-up, the output takes the value on par_code_i. In either mode the shift register also starts out holding the value that par_code_i had at power-up.
- R3: If the block powers up in parallel mode with latch_en_i high, the output equals par_code_i at once and keeps following it while the gate stays high.
- R4: In parallel mode with latch_en_i low, changes on par_code_i leave the output unchanged.
- R5: In parallel mode, a high-then-low pulse on latch_en_i leaves the output holding the last par_code_i value present while the gate was high.
- R6: In parallel mode, sdata_i and sclk_i neither change the output nor alter the shift register contents.
- R7: In serial mode, each rising edge of sclk_i shifts sdata_i into the register, MSB first. After six shifts and a gate pulse, the output equals the 6-bit word.
- R8: In serial mode with latch_en_i low, shifting does not change the output.
- R9: In serial mode with latch_en_i high, the output follows the shift register after each bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset (power-up) |
| ser_mode_i | input | 1 | 0 selects parallel control, 1 selects serial control |
| par_code_i | input | CODE_W | Parallel control word; also the power-up code in serial mode |
| sdata_i | input | 1 | Serial data, MSB first |
| sclk_i | input | 1 | Serial shift clock, sampled and edge-detected |
| latch_en_i | input | 1 | Level-sensitive latch gate |
| pup_sel_i | input | 2 | Preset select {PUP2,PUP1} for parallel power-up |
| atten_code_o | output | CODE_W | Registered attenuation code |

## Verification
The bench builds the block with its defaults: a 6-bit word, two synchronizer stages and the presets 0, 8, 16 and 63. This makes every preset reachable through a full reset sequence, including the all-ones code. With the short synchronizer depth, slow serial clock toggles of a few system cycles are enough to exercise MSB-first shifting and bit-by-bit transparency. The bench also switches modes mid-run, which shows that a shift register left untouched in parallel mode still holds its power-up contents.

// File: rtl/step_atten_ctrl.sv
module step_atten_ctrl #(
  parameter int CODE_W = 6,
  parameter int SYNC_STAGES = 2,
  parameter logic [CODE_W-1:0] PRESET_00 = CODE_W'(0),
  parameter logic [CODE_W-1:0] PRESET_01 = CODE_W'(8),
  parameter logic [CODE_W-1:0] PRESET_10 = CODE_W'(16),
  parameter logic [CODE_W-1:0] PRESET_11 = {CODE_W{1'b1}}
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ser_mode_i,
  input  logic [CODE_W-1:0] par_code_i,
  input  logic              sdata_i,
  input  logic              sclk_i,
  input  logic              latch_en_i,
  input  logic [1:0]        pup_sel_i,
  output logic [CODE_W-1:0] atten_code_o
);

  localparam int CNT_W = $clog2(SYNC_STAGES + 1);
  localparam int TOP   = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] sclk_sy, sdata_sy, le_sy, mode_sy;
  logic [CODE_W-1:0]      par_sy [SYNC_STAGES];
  logic [1:0]             pup_sy [SYNC_STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_sy  <= '0;
      sdata_sy <= '0;
      le_sy    <= '0;
      mode_sy  <= '0;
      for (int i = 0; i < SYNC_STAGES; i++) begin
        par_sy[i] <= '0;
        pup_sy[i] <= '0;
      end
    end else begin
      sclk_sy  <= {sclk_sy[TOP-1:0], sclk_i};
      sdata_sy <= {sdata_sy[TOP-1:0], sdata_i};
      le_sy    <= {le_sy[TOP-1:0], latch_en_i};
      mode_sy  <= {mode_sy[TOP-1:0], ser_mode_i};
      par_sy[0] <= par_code_i;
      pup_sy[0] <= pup_sel_i;
      for (int i = 1; i < SYNC_STAGES; i++) begin
        par_sy[i] <= par_sy[i-1];
        pup_sy[i] <= pup_sy[i-1];
      end
    end
  end

  logic              sclk_s, sdata_s, le_s, mode_s, sclk_d, rise, run;
  logic [CODE_W-1:0] par_s, preset, shreg, code_q;
  logic [1:0]        pup_s;
  logic [CNT_W-1:0]  warm_cnt;

  assign sclk_s  = sclk_sy[TOP];
  assign sdata_s = sdata_sy[TOP];
  assign le_s    = le_sy[TOP];
  assign mode_s  = mode_sy[TOP];
  assign par_s   = par_sy[TOP];
  assign pup_s   = pup_sy[TOP];
  assign rise    = sclk_s & ~sclk_d;

  always_comb begin
    case (pup_s)
      2'b00:   preset = PRESET_00;
      2'b01:   preset = PRESET_01;
      2'b10:   preset = PRESET_10;
      default: preset = PRESET_11;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_d   <= 1'b0;
      run      <= 1'b0;
      warm_cnt <= '0;
      shreg    <= '0;
      code_q   <= '0;
    end else begin
      sclk_d <= sclk_s;
      if (!run) begin
        if (warm_cnt == CNT_W'(SYNC_STAGES)) begin
          run    <= 1'b1;
          shreg  <= par_s;
          code_q <= (mode_s || le_s) ? par_s : preset;
        end else begin
          warm_cnt <= warm_cnt + 1'b1;
        end
      end else begin
        if (mode_s && rise) shreg <= {shreg[CODE_W-2:0], sdata_s};
        if (le_s) code_q <= mode_s ? shreg : par_s;
      end
    end
  end

  assign atten_code_o = code_q;

endmodule

module step_atten_ctrl_chk #(
  parameter int CODE_W = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              run,
  input logic              mode_s,
  input logic              le_s,
  input logic              rise,
  input logic              sdata_s,
  input logic [CODE_W-1:0] par_s,
  input logic [CODE_W-1:0] shreg,
  input logic [CODE_W-1:0] atten_code_o
);

  a_r3_direct_follow: assert property (@(posedge clk) disable iff (!rst_n)
    run && !mode_s && le_s |=> atten_code_o == $past(par_s));

  // R4 and R8: a closed gate holds the output in either mode
  a_r4_hold_when_closed: assert property (@(posedge clk) disable iff (!rst_n)
    run && !le_s |=> $stable(atten_code_o));

  a_r6_no_shift_parallel: assert property (@(posedge clk) disable iff (!rst_n)
    run && !mode_s |=> $stable(shreg));

  a_r7_shift_msb_first: assert property (@(posedge clk) disable iff (!rst_n)
    run && mode_s && rise |=> shreg == {$past(shreg[CODE_W-2:0]), $past(sdata_s)});

  a_r9_transparent: assert property (@(posedge clk) disable iff (!rst_n)
    run && mode_s && le_s |=> atten_code_o == $past(shreg));

endmodule

bind step_atten_ctrl step_atten_ctrl_chk #(.CODE_W(CODE_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .run(run), .mode_s(mode_s), .le_s(le_s),
  .rise(rise), .sdata_s(sdata_s), .par_s(par_s), .shreg(shreg),
  .atten_code_o(atten_code_o)
);

// File: tb/step_atten_ctrl_tb_top.sv
module step_atten_ctrl_tb_top;
  localparam int W = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ser_mode = 1'b0, sdata = 1'b0, sclk = 1'b0, le = 1'b0;
  logic [W-1:0] par = '0;
  logic [1:0] pup = '0;
  logic [W-1:0] code;

  always #10 clk = ~clk;

  step_atten_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .ser_mode_i(ser_mode), .par_code_i(par),
    .sdata_i(sdata), .sclk_i(sclk), .latch_en_i(le), .pup_sel_i(pup),
    .atten_code_o(code)
  );

  int applied = 0, miscmp = 0, pushed = 0, popped = 0;
  bit finished = 1'b0;
  logic [W-1:0] exp_q[$];
  string tag_q[$];
  logic [W-1:0] sr_model;

  // monitor: pops expected items and compares against the output
  initial begin
    forever begin
      wait (pushed > popped);
      @(negedge clk);
      begin
        logic [W-1:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        applied++;
        if (code !== e) begin
          miscmp++;
          $display("FAIL %s: got %0d expected %0d", t, code, e);
        end
        popped++;
      end
    end
  end

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_code(logic [W-1:0] e, string t);
    exp_q.push_back(e);
    tag_q.push_back(t);
    pushed++;
    wait (popped == pushed);
  endtask

  task automatic power_up(logic m, logic [W-1:0] p, logic [1:0] s, logic l);
    rst_n = 1'b0; ser_mode = m; par = p; pup = s; le = l; sclk = 1'b0; sdata = 1'b0;
    cyc(3);
    rst_n = 1'b1;
    sr_model = p;
    cyc(6);
  endtask

  task automatic pulse_le();
    le = 1'b1; cyc(6);
    le = 1'b0; cyc(6);
  endtask

  task automatic shift_bit(logic b, logic track);
    sdata = b; cyc(3);
    sclk = 1'b1; cyc(4);
    sclk = 1'b0; cyc(4);
    if (track) sr_model = {sr_model[W-2:0], b};
  endtask

  task automatic shift_word(logic [W-1:0] w, logic track);
    for (int i = W - 1; i >= 0; i--) shift_bit(w[i], track);
  endtask

  initial begin
    // R1: presets selected by {PUP2,PUP1}
    power_up(1'b0, 6'h2A, 2'b00, 1'b0); expect_code(6'd0,  "R1 pup00");
    power_up(1'b0, 6'h2A, 2'b01, 1'b0); expect_code(6'd8,  "R1 pup01");
    power_up(1'b0, 6'h2A, 2'b10, 1'b0); expect_code(6'd16, "R1 pup10");
    power_up(1'b0, 6'h2A, 2'b11, 1'b0); expect_code(6'd63, "R1 pup11");

    // R2: serial power-up takes the parallel pins, shift register too
    power_up(1'b1, 6'h15, 2'b11, 1'b0); expect_code(6'h15, "R2 serial power-up");
    pulse_le();                          expect_code(6'h15, "R2 shreg preload");

    // R3: parallel power-up with gate high follows pins
    power_up(1'b0, 6'h11, 2'b00, 1'b1); expect_code(6'h11, "R3 direct at power-up");
    par = 6'h2C; cyc(6);                 expect_code(6'h2C, "R3 direct follow");

    // R4: gate low blocks parallel changes
    le = 1'b0; cyc(6);
    par = 6'h07; cyc(6);                 expect_code(6'h2C, "R4 hold a");
    par = 6'h33; cyc(6);                 expect_code(6'h2C, "R4 hold b");

    // R5: latched capture of last value while gate high
    par = 6'h19; le = 1'b1; cyc(6);
    par = 6'h05; cyc(6);
    le = 1'b0; cyc(6);
    par = 6'h3F; cyc(6);                 expect_code(6'h05, "R5 latched capture");

    // R6: serial pins ignored in parallel mode
    shift_word(6'h3C, 1'b0);             expect_code(6'h05, "R6 gate low");
    par = 6'h05; le = 1'b1; cyc(6);
    shift_word(6'h2A, 1'b0);             expect_code(6'h05, "R6 gate high");
    le = 1'b0; cyc(6);
    ser_mode = 1'b1; cyc(6);
    pulse_le();                          expect_code(6'h11, "R6 shreg untouched");

    // R7 / R8: serial load behind a closed gate, then pulse
    shift_word(6'h2D, 1'b1);             expect_code(6'h11, "R8 closed gate");
    pulse_le();                          expect_code(6'h2D, "R7 word 2D");
    shift_word(6'h12, 1'b1);             expect_code(6'h2D, "R8 closed gate b");
    pulse_le();                          expect_code(6'h12, "R7 word 12");

    // R9: transparent gate follows each shifted bit
    le = 1'b1; cyc(6);
    for (int i = W - 1; i >= 0; i--) begin
      shift_bit(1'b1 ^ (i == 2), 1'b1);
      expect_code(sr_model, "R9 transparent bit");
    end
    le = 1'b0; cyc(6);

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", applied, miscmp);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      applied++;
      miscmp++;
      $display("FAIL watchdog: got 0 expected 1 (run completed)");
      $display("== %0d vectors applied, %0d miscompares ==", applied, miscmp);
      $finish;
    end
  end
endmodule